// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block holds the digital control and status around an analog voltage comparator. The comparator's raw output comes in without any clock relationship. It passes through a flop synchronizer, and a startup timer blanks it after the comparator is switched on. Low-to-high and high-to-low transitions of the blanked level set two separate sticky flags. Each flag has its own interrupt enable. A global enable input gates the combined request, which is a level output.

Software uses a small register port. One write port sets the enable, the 4-bit hysteresis code, the per-edge interrupt enables and the blanking length. Writing ones to the flag bit positions clears the flags. A combinational read port returns the live comparator level, the flags and every setting. The hysteresis code is only stored and driven out to the analog side.

Top module: `cei_edge_irq`

## Requirements
- R1: The raw comparator input reaches the live level through SYNC_STAGES flops (default 2). A change on the input that is sampled at edge t can be read as the live bit after edge t+1.
- R2: The rise flag (control register bit 5) is set one cycle after the synchronized level goes from 0 to 1. This happens only while the output is valid, and only if it was also valid in the previous cycle.
- R3: The fall flag (control register bit 4) is set the same way on a 1-to-0 transition of the synchronized level.
- R4: A flag stays set until a write to the control register (address 0) with a one in that flag's bit position. A zero in that position leaves the flag alone. When a hardware set and a clear fall in the same cycle, the flag ends up set.
- R5: Control register bit 6 returns the live level at all times. It reads 0 whenever the comparator is disabled or blanked. Writes to bit 6 have no effect.
- R6: irq_o = glob_ie_i AND ((rise flag AND rise enable) OR (fall flag AND fall enable)). There is no register between these terms and the output.
- R7: A write that sets control bit 7 while it is 0 loads the blanking counter from the blanking register (address 2, CNT_W bits, reset value RST_BLANK). The output becomes valid once the counter reaches zero, and it counts down by one per cycle.
- R8: Control bits 3..0 hold the hysteresis code. This code is driven on hyst_o and reads back unchanged. It reset to 0.
- R9: The mode register (address 1) holds the rise interrupt enable in bit 1 and the fall interrupt enable in bit 0. Address 3 reads zero.
- R10: A write that clears control bit 7 turns the comparator off and zeroes the counter. Writing bit 7 as 1 while it is already 1 does not reload the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw_i | input | 1 | Unsynchronized comparator output |
| glob_ie_i | input | 1 | Global comparator interrupt enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| hyst_o | output | 4 | Hysteresis code to the analog comparator |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardware flag set and the software write-one-to-clear can fall in the same cycle. To provoke this, the bench toggles the comparator input and then issues clear writes at a sweep of offsets after the toggle. One of those offsets lands on the exact cycle in which the detected edge is registered. A behavioural model updates its flags each cycle with the set taking priority, and every cycle the flag bits read back are compared with it. A design where the clear wins loses the new flag, and that difference shows in the compare.

// File: rtl/cei_pkg.sv
package cei_pkg;
   localparam int DATA_W = 8;
   typedef enum logic [1:0] {
      REG_CTL   = 2'd0,
      REG_MODE  = 2'd1,
      REG_BLANK = 2'd2,
      REG_RSVD  = 2'd3
   } cei_reg_e;
   localparam int BIT_EN   = 7;
   localparam int BIT_LIVE = 6;
   localparam int BIT_RF   = 5;
   localparam int BIT_FF   = 4;
   localparam int BIT_RIE  = 1;
   localparam int BIT_FIE  = 0;
   localparam int HYST_W   = 4;
endpackage

// File: rtl/cei_sync.sv
module cei_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("cei_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cei_blank.sv
module cei_blank #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             valid_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (stop_i)         cnt_q <= '0;
      else if (start_i)        cnt_q <= len_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign valid_o = en_i && (cnt_q == '0);
endmodule

// File: rtl/cei_edge.sv
module cei_edge #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic valid_i,
   input  logic lvl_i,
   input  logic clr_rise_i,
   input  logic clr_fall_i,
   output logic rise_f_o,
   output logic fall_f_o
);
   logic prev_q, vd_q;
   logic rise_ev, fall_ev;
   logic rise_n, fall_n;

   assign rise_ev = valid_i && vd_q &&  lvl_i && !prev_q;
   assign fall_ev = valid_i && vd_q && !lvl_i &&  prev_q;

   generate
      if (SET_WINS) begin : g_set_wins
         assign rise_n = rise_ev | (rise_f_o & ~clr_rise_i);
         assign fall_n = fall_ev | (fall_f_o & ~clr_fall_i);
      end else begin : g_clr_wins
         assign rise_n = (rise_ev | rise_f_o) & ~clr_rise_i;
         assign fall_n = (fall_ev | fall_f_o) & ~clr_fall_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= 1'b0;
         vd_q     <= 1'b0;
         rise_f_o <= 1'b0;
         fall_f_o <= 1'b0;
      end else begin
         prev_q   <= lvl_i;
         vd_q     <= valid_i;
         rise_f_o <= rise_n;
         fall_f_o <= fall_n;
      end
   end
endmodule

// File: rtl/cei_edge_irq.sv
module cei_edge_irq
   import cei_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 8,
   parameter int RST_BLANK   = 16,
   parameter bit SET_WINS    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_raw_i,
   input  logic              glob_ie_i,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_addr_i,
   input  logic [7:0]        wr_data_i,
   input  logic [1:0]        rd_addr_i,
   output logic [7:0]        rd_data_o,
   output logic [3:0]        hyst_o,
   output logic              irq_o
);
   localparam logic [CNT_W-1:0] BLANK_INIT = CNT_W'(RST_BLANK);

   generate
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("cei_edge_irq: CNT_W must lie in 1..8");
      end
      if (RST_BLANK < 0 || RST_BLANK >= (1 << CNT_W)) begin : g_bad_rst
         $error("cei_edge_irq: RST_BLANK does not fit in CNT_W bits");
      end
   endgenerate

   logic              en_q, rie_q, fie_q;
   logic [HYST_W-1:0] hyst_q;
   logic [CNT_W-1:0]  blank_q;
   logic              ctl_wr, mode_wr, blank_wr;
   logic              start, stop;
   logic              sync_lvl, blank_valid, live_lvl;
   logic              rise_f, fall_f;

   assign ctl_wr   = wr_en_i && (wr_addr_i == REG_CTL);
   assign mode_wr  = wr_en_i && (wr_addr_i == REG_MODE);
   assign blank_wr = wr_en_i && (wr_addr_i == REG_BLANK);
   assign start    = ctl_wr &&  wr_data_i[BIT_EN] && !en_q;
   assign stop     = ctl_wr && !wr_data_i[BIT_EN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         hyst_q  <= '0;
         rie_q   <= 1'b0;
         fie_q   <= 1'b0;
         blank_q <= BLANK_INIT;
      end else begin
         if (ctl_wr) begin
            en_q   <= wr_data_i[BIT_EN];
            hyst_q <= wr_data_i[HYST_W-1:0];
         end
         if (mode_wr) begin
            rie_q <= wr_data_i[BIT_RIE];
            fie_q <= wr_data_i[BIT_FIE];
         end
         if (blank_wr) blank_q <= wr_data_i[CNT_W-1:0];
      end
   end

   cei_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(cmp_raw_i), .q_o(sync_lvl)
   );

   cei_blank #(.CNT_W(CNT_W)) u_blank (
      .clk(clk), .rst_n(rst_n), .en_i(en_q), .start_i(start),
      .stop_i(stop), .len_i(blank_q), .valid_o(blank_valid)
   );

   cei_edge #(.SET_WINS(SET_WINS)) u_edge (
      .clk(clk), .rst_n(rst_n), .valid_i(blank_valid), .lvl_i(sync_lvl),
      .clr_rise_i(ctl_wr && wr_data_i[BIT_RF]),
      .clr_fall_i(ctl_wr && wr_data_i[BIT_FF]),
      .rise_f_o(rise_f), .fall_f_o(fall_f)
   );

   assign live_lvl = blank_valid && sync_lvl;
   assign hyst_o   = hyst_q;
   assign irq_o    = glob_ie_i && ((rise_f && rie_q) || (fall_f && fie_q));

   always_comb begin
      rd_data_o = '0;
      case (cei_reg_e'(rd_addr_i))
         REG_CTL: begin
            rd_data_o[BIT_EN]       = en_q;
            rd_data_o[BIT_LIVE]     = live_lvl;
            rd_data_o[BIT_RF]       = rise_f;
            rd_data_o[BIT_FF]       = fall_f;
            rd_data_o[HYST_W-1:0]   = hyst_q;
         end
         REG_MODE: begin
            rd_data_o[BIT_RIE] = rie_q;
            rd_data_o[BIT_FIE] = fie_q;
         end
         REG_BLANK: rd_data_o = DATA_W'(blank_q);
         default:   rd_data_o = '0;
      endcase
   end
endmodule

// File: rtl/cei_chk.sv
module cei_chk
   import cei_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       glob_ie_i,
   input logic       irq_o,
   input logic [3:0] hyst_o,
   input logic       ctl_wr,
   input logic [7:0] wr_data_i,
   input logic       en_q,
   input logic       blank_valid,
   input logic       live_lvl,
   input logic       rise_f,
   input logic       fall_f
);
   assert_rise_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_f && !(ctl_wr && wr_data_i[BIT_RF])) |=> rise_f);
   assert_fall_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_f && !(ctl_wr && wr_data_i[BIT_FF])) |=> fall_f);
   assert_global_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_ie_i |-> !irq_o);
   assert_off_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !live_lvl);
   assert_rise_only_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rise_f) |-> $past(blank_valid));
   assert_fall_only_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fall_f) |-> $past(blank_valid));
   assert_hyst_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> $stable(hyst_o));
endmodule

bind cei_edge_irq cei_chk u_chk (
   .clk(clk), .rst_n(rst_n), .glob_ie_i(glob_ie_i), .irq_o(irq_o),
   .hyst_o(hyst_o), .ctl_wr(ctl_wr), .wr_data_i(wr_data_i), .en_q(en_q),
   .blank_valid(blank_valid), .live_lvl(live_lvl), .rise_f(rise_f),
   .fall_f(fall_f)
);

// File: tb/sim_cei_edge_irq.sv
`timescale 1ns/100ps
module sim_cei_edge_irq;
   localparam int RST_BLANK = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmp_raw = 1'b0;
   logic       gie = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [3:0] hyst;
   logic       irq;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   always #2 clk = ~clk;

   cei_edge_irq #(.RST_BLANK(RST_BLANK)) u0 (
      .clk(clk), .rst_n(rst_n), .cmp_raw_i(cmp_raw), .glob_ie_i(gie),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data), .hyst_o(hyst), .irq_o(irq)
   );

   // behavioural reference model
   bit m_s1, m_s2, m_prev, m_vd, m_en, m_rf, m_ff, m_rie, m_fie;
   int m_cnt, m_blank, m_hyst;

   function automatic bit m_valid();
      return m_en && (m_cnt == 0);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_prev = 0; m_vd = 0; m_en = 0;
         m_rf = 0; m_ff = 0; m_rie = 0; m_fie = 0;
         m_cnt = 0; m_blank = RST_BLANK; m_hyst = 0;
      end else begin
         bit v, rise, fall, cw;
         v    = m_valid();
         rise = v && m_vd && m_s2 && !m_prev;
         fall = v && m_vd && !m_s2 && m_prev;
         cw   = wr_en && (wr_addr == 2'd0);
         m_rf = rise || (m_rf && !(cw && wr_data[5]));
         m_ff = fall || (m_ff && !(cw && wr_data[4]));
         if (cw) begin
            if (!wr_data[7])      m_cnt = 0;
            else if (!m_en)       m_cnt = m_blank;
            else if (m_cnt > 0)   m_cnt--;
            m_en   = wr_data[7];
            m_hyst = wr_data[3:0];
         end else if (m_cnt > 0) m_cnt--;
         if (wr_en && wr_addr == 2'd1) begin m_rie = wr_data[1]; m_fie = wr_data[0]; end
         if (wr_en && wr_addr == 2'd2) m_blank = wr_data;
         m_vd = v; m_prev = m_s2; m_s2 = m_s1; m_s1 = cmp_raw;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
      end
   endtask

   task automatic compare();
      bit live;
      live = m_valid() && m_s2;
      chk("R6 irq", irq, gie && ((m_rf && m_rie) || (m_ff && m_fie)));
      chk("R8 hyst_o", hyst, m_hyst);
      case (rd_addr)
         2'd0: begin
            chk("R5/R1 live bit", rd_data[6], live);
            chk("R2 rise flag", rd_data[5], m_rf);
            chk("R3 fall flag", rd_data[4], m_ff);
            chk("R10 enable bit", rd_data[7], m_en);
            chk("R8 hyst readback", rd_data[3:0], m_hyst);
         end
         2'd1: chk("R9 mode reg", rd_data, {6'b0, m_rie, m_fie});
         2'd2: chk("R7 blank reg", rd_data, m_blank);
         default: chk("R9 reserved", rd_data, 0);
      endcase
   endtask

   task automatic step(input bit we = 0, input logic [1:0] wa = 0, input logic [7:0] wd = 0);
      @(negedge clk);
      cyc++;
      wr_en = we; wr_addr = wa; wr_data = wd;
      rd_addr = 2'(cyc);
      #1;
      compare();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic toggle_and_clear(input int off);
      cmp_raw = ~cmp_raw;
      for (int i = 0; i < 6; i++) begin
         if (i == off) step(1, 2'd0, 8'hB0 | 8'(m_hyst));
         else          step();
      end
   endtask

   initial begin
      #1000000;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // reset state
      idle(4);
      // R9 mode: both edges enabled; R7 short blanking
      step(1, 2'd1, 8'h03);
      step(1, 2'd2, 8'd5);
      gie = 1'b1;
      cmp_raw = 1'b1;
      step(1, 2'd0, 8'h8A);           // enable, hyst A
      // R7: toggles inside blanking must not flag
      for (int i = 0; i < 5; i++) begin cmp_raw = ~cmp_raw; step(); end
      idle(4);
      // R2/R3 edges, R4 clear at swept offsets (incl. coincident cycle)
      for (int off = 0; off < 6; off++) toggle_and_clear(off);
      // R10 re-write enable while on: no reload
      step(1, 2'd0, 8'h85);
      idle(3);
      // R6 global gate off, flags accumulate
      gie = 1'b0;
      cmp_raw = ~cmp_raw; idle(4);
      cmp_raw = ~cmp_raw; idle(4);
      gie = 1'b1; idle(2);
      // R9 only rising enabled
      step(1, 2'd1, 8'h02);
      step(1, 2'd0, 8'hB5); idle(2);
      cmp_raw = 1'b0; idle(4);
      cmp_raw = 1'b1; idle(4);
      // R5 live bit write ignored
      step(1, 2'd0, 8'hC5); idle(3);
      // R10 disable then toggle: nothing flagged, live 0
      step(1, 2'd0, 8'h30);
      for (int i = 0; i < 4; i++) begin cmp_raw = ~cmp_raw; idle(3); end
      // R7 re-enable with zero blanking
      step(1, 2'd2, 8'd0);
      step(1, 2'd1, 8'h01);
      step(1, 2'd0, 8'h87);
      for (int i = 0; i < 6; i++) begin cmp_raw = ~cmp_raw; idle(2); end
      // fast input pulses
      for (int i = 0; i < 12; i++) begin cmp_raw = i[0]; step(); end
      idle(4);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule